// File: doc/BRIEF.md
# Host Bus State Controller

This block holds the bus state of a full-speed host controller. The four states are reset, resume, operational and suspend. Software asks for a new state through a request strobe and a 2-bit target. The remote wakeup detector and the root hub's local wakeup logic can also move the bus from suspend to resume. A separate software-reset strobe puts the controller into suspend from any state.

The block decides which request wins when several arrive in the same cycle. It rejects moves that the transition graph forbids and applies two timing guards that count from the moment suspend is entered. A 1 kHz tick drives a dwell counter. Resume from suspend, whether requested by software or by a local wakeup, must wait five ticks. A direct jump to operational is allowed only after a software reset, and only before the first tick. A rejected request leaves the state unchanged and sets a sticky error flag, which only the hardware reset clears.

The state register feeds the enables for list processing and SOF token generation. It also feeds the two commands that tell the port logic to drive reset or resume signaling.

Top module: `host_bus_state_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, the state code is 0 (reset), `drive_reset` is 1, every other output is 0, and `req_error` is 0. Asserting `rst_n` low at any time returns the block to this condition.
- R2: `state_code` reports the state as 0 = reset, 1 = resume, 2 = operational, 3 = suspend. `list_en` and `sof_en` are 1 only while the state is 2.
- R3: `drive_reset` is 1 only in state 0. `drive_resume` is 1 only in state 1. Resume signaling therefore stops on the same edge that makes SOF generation possible.
- R4: A software request for state 0 is accepted from every state.
- R5: From state 0, software may move only to state 2. From state 2, software may move only to state 0 or state 3.
- R6: State 1 is entered only from state 3. From state 1, software may move only to state 0 or state 2. A software request for state 1 while in state 3 is accepted only once at least 5 ticks have counted since suspend was entered.
- R7: In state 3, `remote_wake` moves the block to state 1 on the next edge, with no dwell guard. If a software request for state 0 arrives in the same cycle, the request for state 0 wins.
- R8: In state 3, `local_wake` moves the block to state 1 only once at least 5 ticks have counted since suspend was entered. Before that it has no effect. The dwell count saturates, so any number of extra ticks still allows the move.
- R9: `soft_rst` moves the block to state 3 from any state, including state 3, and restarts the dwell count. After this entry, a software request for state 2 is accepted only while no tick has counted. Suspend entered from state 2 never allows a direct move to state 2.
- R10: A software request that R5, R6 or R9 forbids leaves the state unchanged and sets `req_error`. `req_error` stays 1 until the hardware reset. A request for the current state is a no-op and does not set `req_error`.
- R11: `remote_wake` and `local_wake` have no effect outside state 3.
- R12: `soft_rst` has priority over a software request and over both wakeups that arrive in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Software reset strobe |
| req_valid | input | 1 | Software state request strobe |
| req_state | input | 2 | Requested state code |
| remote_wake | input | 1 | Remote wakeup detected on the bus |
| local_wake | input | 1 | Local wakeup request from the root hub |
| ms_tick | input | 1 | One-cycle pulse at 1 kHz |
| state_code | output | 2 | Current bus state code |
| list_en | output | 1 | List processing enable |
| sof_en | output | 1 | SOF token generation enable |
| drive_reset | output | 1 | Port command: drive reset signaling |
| drive_resume | output | 1 | Port command: drive resume signaling |
| req_error | output | 1 | Sticky flag for a rejected request |

## Verification
The bench targets the edges of the two dwell windows.

- Resume is requested at four ticks and at five ticks. A counter that is off by one would either release resume one tick early or hold it one tick too long.
- A jump to operational is requested with no tick after a software reset, and again after one tick. A design that keeps the window open, or opens it for a normal suspend entry, would wrongly accept the second request.
- The bench applies conflicting inputs in the same cycle: remote wakeup with a reset request, and software reset with a request plus a wakeup. A wrong priority order would leave the bus in resume or operational.
- A software reset issued while already in suspend checks that the dwell count restarts rather than continuing.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

  typedef enum logic [1:0] {
    HBS_RESET   = 2'd0,
    HBS_RESUME  = 2'd1,
    HBS_OPER    = 2'd2,
    HBS_SUSPEND = 2'd3
  } hbs_state_e;

endpackage

// File: rtl/hbs_rst_sync.sv
module hbs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/hbs_dwell_timer.sv
module hbs_dwell_timer #(
  parameter int RESUME_GUARD_MS = 5,
  parameter int OPER_WINDOW_MS  = 1
) (
  input  logic clk,
  input  logic rst_sn,
  input  logic enter_susp,
  input  logic enter_soft,
  input  logic in_susp,
  input  logic ms_tick,
  output logic resume_ok,
  output logic oper_ok
);
  localparam int SAT = (RESUME_GUARD_MS > OPER_WINDOW_MS) ? RESUME_GUARD_MS : OPER_WINDOW_MS;
  localparam int CW  = $clog2(SAT + 1);
  localparam logic [CW-1:0] SAT_V   = CW'(SAT);
  localparam logic [CW-1:0] GUARD_V = CW'(RESUME_GUARD_MS);
  localparam logic [CW-1:0] WIN_V   = CW'(OPER_WINDOW_MS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          soft_win_q, soft_win_d;
  logic          cnt_en;

  always_comb begin
    cnt_en     = enter_susp || (in_susp && ms_tick && (cnt_q != SAT_V));
    cnt_d      = enter_susp ? '0 : cnt_q + 1'b1;
    soft_win_d = enter_susp ? enter_soft : soft_win_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cnt_q      <= '0;
      soft_win_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      soft_win_q <= soft_win_d;
    end
  end

  assign resume_ok = (cnt_q >= GUARD_V);
  assign oper_ok   = soft_win_q && (cnt_q < WIN_V);

  // R8: a fresh suspend entry always closes the resume guard
  p_guard_closed_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    enter_susp |=> !resume_ok);

  // R9: the operational window opens only on a software-reset entry
  p_window_soft_only_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    (enter_susp && !enter_soft) |=> !oper_ok);
endmodule

// File: rtl/hbs_next_state.sv
module hbs_next_state
  import hbs_pkg::*;
(
  input  hbs_state_e state_q,
  input  logic       soft_rst,
  input  logic       req_valid,
  input  logic [1:0] req_state,
  input  logic       remote_wake,
  input  logic       local_wake,
  input  logic       resume_ok,
  input  logic       oper_ok,
  output hbs_state_e state_d,
  output logic       enter_susp,
  output logic       enter_soft,
  output logic       illegal
);
  hbs_state_e target;
  logic       legal;
  logic       req_reset;
  logic       in_susp;

  always_comb begin
    target    = hbs_state_e'(req_state);
    req_reset = req_valid && (target == HBS_RESET);
    in_susp   = (state_q == HBS_SUSPEND);

    unique case (state_q)
      HBS_RESET:   legal = (target == HBS_RESET) || (target == HBS_OPER);
      HBS_OPER:    legal = (target != HBS_RESUME);
      HBS_SUSPEND: legal = (target == HBS_RESET) || (target == HBS_SUSPEND) ||
                           ((target == HBS_RESUME) && resume_ok) ||
                           ((target == HBS_OPER) && oper_ok);
      default:     legal = (target != HBS_SUSPEND);
    endcase

    state_d = state_q;
    illegal = 1'b0;
    if (soft_rst) begin
      state_d = HBS_SUSPEND;
    end else if (req_reset) begin
      state_d = HBS_RESET;
    end else if (in_susp && remote_wake) begin
      state_d = HBS_RESUME;
    end else if (req_valid) begin
      if (legal) state_d = target;
      else       illegal = 1'b1;
    end else if (in_susp && local_wake && resume_ok) begin
      state_d = HBS_RESUME;
    end

    enter_soft = soft_rst;
    enter_susp = soft_rst || (!in_susp && (state_d == HBS_SUSPEND));
  end
endmodule

// File: rtl/hbs_bus_outputs.sv
module hbs_bus_outputs
  import hbs_pkg::*;
(
  input  hbs_state_e state_q,
  output logic [1:0] state_code,
  output logic       list_en,
  output logic       sof_en,
  output logic       drive_reset,
  output logic       drive_resume
);
  always_comb begin
    state_code   = state_q;
    list_en      = (state_q == HBS_OPER);
    sof_en       = (state_q == HBS_OPER);
    drive_reset  = (state_q == HBS_RESET);
    drive_resume = (state_q == HBS_RESUME);
  end
endmodule

// File: rtl/host_bus_state_ctrl.sv
module host_bus_state_ctrl
  import hbs_pkg::*;
#(
  parameter int RESUME_GUARD_MS = 5,
  parameter int OPER_WINDOW_MS  = 1,
  parameter int SYNC_STAGES     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       req_valid,
  input  logic [1:0] req_state,
  input  logic       remote_wake,
  input  logic       local_wake,
  input  logic       ms_tick,
  output logic [1:0] state_code,
  output logic       list_en,
  output logic       sof_en,
  output logic       drive_reset,
  output logic       drive_resume,
  output logic       req_error
);
  logic       rst_sn;
  hbs_state_e state_q, state_d;
  logic       err_q;
  logic       enter_susp, enter_soft, illegal;
  logic       resume_ok, oper_ok;

  hbs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  hbs_dwell_timer #(
    .RESUME_GUARD_MS(RESUME_GUARD_MS),
    .OPER_WINDOW_MS (OPER_WINDOW_MS)
  ) u_timer (
    .clk(clk), .rst_sn(rst_sn),
    .enter_susp(enter_susp), .enter_soft(enter_soft),
    .in_susp(state_q == HBS_SUSPEND), .ms_tick(ms_tick),
    .resume_ok(resume_ok), .oper_ok(oper_ok)
  );

  hbs_next_state u_next (
    .state_q(state_q), .soft_rst(soft_rst),
    .req_valid(req_valid), .req_state(req_state),
    .remote_wake(remote_wake), .local_wake(local_wake),
    .resume_ok(resume_ok), .oper_ok(oper_ok),
    .state_d(state_d), .enter_susp(enter_susp),
    .enter_soft(enter_soft), .illegal(illegal)
  );

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= HBS_RESET;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (illegal) err_q <= 1'b1;
    end
  end

  hbs_bus_outputs u_out (
    .state_q(state_q), .state_code(state_code),
    .list_en(list_en), .sof_en(sof_en),
    .drive_reset(drive_reset), .drive_resume(drive_resume)
  );

  assign req_error = err_q;

  // R4
  p_reset_any_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    (!soft_rst && req_valid && req_state == 2'd0) |=> state_q == HBS_RESET);

  // R6
  p_resume_entry_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == HBS_RESUME && $past(state_q) != HBS_RESUME) |-> $past(state_q) == HBS_SUSPEND);

  // R7
  p_remote_wake_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == HBS_SUSPEND && remote_wake && !soft_rst && !(req_valid && req_state == 2'd0))
      |=> state_q == HBS_RESUME);

  // R12
  p_soft_first_r12: assert property (@(posedge clk) disable iff (!rst_sn)
    soft_rst |=> state_q == HBS_SUSPEND);

  // R10
  p_reject_holds_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    illegal |=> $stable(state_q) && err_q);

  // R10
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    err_q |=> err_q);
endmodule

// File: tb/host_bus_state_ctrl_bench.sv
`timescale 1ns/1ps
module host_bus_state_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       soft_rst, req_valid, remote_wake, local_wake, ms_tick;
  logic [1:0] req_state;
  logic [1:0] state_code;
  logic       list_en, sof_en, drive_reset, drive_resume, req_error;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  host_bus_state_ctrl u_host_bus_state_ctrl (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .req_valid(req_valid), .req_state(req_state),
    .remote_wake(remote_wake), .local_wake(local_wake), .ms_tick(ms_tick),
    .state_code(state_code), .list_en(list_en), .sof_en(sof_en),
    .drive_reset(drive_reset), .drive_resume(drive_resume),
    .req_error(req_error)
  );

  // vector: [13:10] req id, [9] soft, [8] req_valid, [7:6] req_state,
  //         [5] remote, [4] local, [3] tick, [2:1] exp state, [0] exp error
  function automatic logic [13:0] mkv(int r, bit sf, bit rv, int rs, bit rw,
                                      bit lw, bit tk, int es, bit ee);
    return {4'(r), sf, rv, 2'(rs), rw, lw, tk, 2'(es), ee};
  endfunction

  localparam int NV = 40;
  localparam logic [13:0] VEC [NV] = '{
    mkv(1, 0,0,0,0,0,0, 0,0), // R1 idle
    mkv(5, 0,1,2,0,0,0, 2,0), // R5 reset->oper
    mkv(2, 0,0,0,0,0,0, 2,0), // R2 hold
    mkv(5, 0,1,3,0,0,0, 3,0), // R5 oper->suspend
    mkv(8, 0,0,0,0,0,1, 3,0), // R8 tick1
    mkv(8, 0,0,0,0,0,1, 3,0),
    mkv(8, 0,0,0,0,0,1, 3,0),
    mkv(8, 0,0,0,0,0,1, 3,0), // tick4
    mkv(8, 0,0,0,0,1,0, 3,0), // R8 local wake blocked at 4
    mkv(8, 0,0,0,0,0,1, 3,0), // tick5
    mkv(8, 0,0,0,0,1,0, 1,0), // R8 local wake allowed
    mkv(11,0,0,0,1,0,0, 1,0), // R11 remote in resume
    mkv(6, 0,1,2,0,0,0, 2,0), // R6 resume->oper
    mkv(11,0,0,0,1,1,0, 2,0), // R11 wakes in oper
    mkv(5, 0,1,3,0,0,0, 3,0),
    mkv(7, 0,0,0,1,0,0, 1,0), // R7 remote wake unguarded
    mkv(4, 0,1,0,0,0,0, 0,0), // R4 resume->reset
    mkv(5, 0,1,2,0,0,0, 2,0),
    mkv(5, 0,1,3,0,0,0, 3,0),
    mkv(7, 0,1,0,1,0,0, 0,0), // R7 reset beats remote wake
    mkv(5, 0,1,2,0,0,0, 2,0),
    mkv(9, 1,0,0,0,0,0, 3,0), // R9 soft reset
    mkv(9, 0,1,2,0,0,0, 2,0), // R9 oper within window
    mkv(9, 1,0,0,0,0,0, 3,0),
    mkv(9, 0,0,0,0,0,1, 3,0), // window closes
    mkv(10,0,1,2,0,0,0, 3,1), // R10 late oper rejected
    mkv(6, 0,1,1,0,0,0, 3,1), // R6 early resume rejected
    mkv(6, 0,0,0,0,0,1, 3,1),
    mkv(6, 0,0,0,0,0,1, 3,1),
    mkv(6, 0,0,0,0,0,1, 3,1),
    mkv(6, 0,0,0,0,0,1, 3,1), // count 5
    mkv(6, 0,1,1,0,0,0, 1,1), // R6 resume allowed
    mkv(6, 0,1,3,0,0,0, 1,1), // R6 resume->suspend rejected
    mkv(4, 0,1,0,0,0,0, 0,1),
    mkv(6, 0,1,1,0,0,0, 0,1), // R6 reset->resume rejected
    mkv(10,0,1,3,0,0,0, 0,1), // R10 reset->suspend rejected
    mkv(12,1,1,2,1,0,0, 3,1), // R12 soft beats all
    mkv(9, 0,1,2,0,0,0, 2,1),
    mkv(11,0,0,0,0,1,1, 2,1), // R11 local wake in oper
    mkv(5, 0,1,1,0,0,0, 2,1)  // R5 oper->resume rejected
  };

  task automatic drive(bit sf, bit rv, int rs, bit rw, bit lw, bit tk);
    soft_rst = sf; req_valid = rv; req_state = 2'(rs);
    remote_wake = rw; local_wake = lw; ms_tick = tk;
  endtask

  task automatic check(int r, logic [1:0] es, logic ee);
    bit bad = 0;
    n_chk++;
    if (state_code !== es || req_error !== ee) begin
      $display("FAIL R%0d state/err got %0d/%0b exp %0d/%0b", r, state_code, req_error, es, ee);
      bad = 1;
    end
    if (list_en !== (es == 2'd2) || sof_en !== (es == 2'd2)) begin
      $display("FAIL R2 list/sof got %0b/%0b exp %0b", list_en, sof_en, es == 2'd2);
      bad = 1;
    end
    if (drive_reset !== (es == 2'd0) || drive_resume !== (es == 2'd1)) begin
      $display("FAIL R3 drive rst/res got %0b/%0b exp %0b/%0b",
               drive_reset, drive_resume, es == 2'd0, es == 2'd1);
      bad = 1;
    end
    if (bad) n_fail++;
  endtask

  task automatic step(int r, bit sf, bit rv, int rs, bit rw, bit lw, bit tk,
                      logic [1:0] es, logic ee);
    drive(sf, rv, rs, rw, lw, tk);
    @(negedge clk);
    check(r, es, ee);
  endtask

  task automatic hw_reset();
    drive(0,0,0,0,0,0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(1, 2'd0, 1'b0); // R1 during reset
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(1, 2'd0, 1'b0); // R1 after release
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    hw_reset();
    for (int i = 0; i < NV; i++) begin
      logic [13:0] v = VEC[i];
      step(int'(v[13:10]), v[9], v[8], int'(v[7:6]), v[5], v[4], v[3], v[2:1], v[0]);
    end

    hw_reset();
    step(10, 0,1,0,0,0,0, 2'd0, 1'b0); // R10 same-state request is no error
    step(5,  0,1,2,0,0,0, 2'd2, 1'b0);
    step(5,  0,1,3,0,0,0, 2'd3, 1'b0);
    step(9,  0,1,2,0,0,0, 2'd3, 1'b1); // R9 no window after normal entry
    for (int k = 0; k < 10; k++) step(8, 0,0,0,0,0,1, 2'd3, 1'b1);
    step(8,  0,0,0,0,1,0, 2'd1, 1'b1); // R8 saturated count still releases
    step(6,  0,1,2,0,0,0, 2'd2, 1'b1);
    step(5,  0,1,3,0,0,0, 2'd3, 1'b1);
    for (int k = 0; k < 5; k++) step(9, 0,0,0,0,0,1, 2'd3, 1'b1);
    step(9,  1,0,0,0,0,0, 2'd3, 1'b1); // R9 soft reset restarts dwell
    step(9,  0,1,1,0,0,0, 2'd3, 1'b1); // resume now rejected again
    step(8,  0,0,0,0,1,0, 2'd3, 1'b1); // R8 local wake blocked again
    drive(0,0,0,0,0,0);
    rst_n = 1'b0;                      // R1 asynchronous return
    #1;
    n_chk++;
    if (state_code !== 2'd0 || req_error !== 1'b0 || drive_reset !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 async reset got %0d/%0b exp 0/0", state_code, req_error);
    end
    hw_reset();

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule